// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter with Terminal Flags

This block is a synchronous binary counter, four bits wide by default. A direction input selects whether it counts up or down. An active-low enable gates counting, and a data bus can be loaded through an active-low load input. The load is level-sensitive and does not wait for a clock edge: while it is held low, the count output follows the data bus straight away, and the stored value is refreshed at every clock edge during the load.

Two outputs support cascading. A terminal-count flag is raised while counting is enabled and the count sits at its last value in the chosen direction: all ones when counting up, zero when counting down. An active-low ripple output pulses low only during the low half of the clock while that flag is raised.

A build-time reload option adds a zero detector. Whenever the stored count is zero, the block presents a preset value (6 by default) as if a load were active. With this option an up-counter steps through 6, 7, ... 15 and then returns to 6.

Top module: `updn_counter`

## Requirements
- R1: Driving `rst_n` low clears the stored count to 0 at once, without waiting for a clock edge. In reload mode the output then reads the preset value, 6.
- R2: With `load_n` high, `cnt_en_n` low and `dir_down` low (0 means up), each rising clock edge adds one to `count`.
- R3: With `load_n` high, `cnt_en_n` low and `dir_down` high (1 means down), each rising clock edge subtracts one from `count`.
- R4: With `load_n` high and `cnt_en_n` high, `count` holds across clock edges.
- R5: While `load_n` is low, `count` equals `din` immediately, with no clock edge needed. A clock edge during the load stores `din`, whatever the enable or direction inputs say.
- R6: Without reload, counting up from 15 gives 0 and counting down from 0 gives 15.
- R7: `term_cnt` is high exactly when `cnt_en_n` is low and either the direction is up with `count` at 15, or the direction is down with `count` at 0. It is low whenever `cnt_en_n` is high.
- R8: `ripple_n` is low only while `term_cnt` is high and `clk` is low. It is high throughout the high phase of the clock.
- R9: In reload mode (`RELOAD_EN`=1, `PRESET`=6), a stored zero is presented as 6. Counting up therefore runs 6, 7, ... 15, 6, and `term_cnt` is raised at 15.
- R10: After `load_n` returns high, `count` keeps the value loaded at the last clock edge, and counting resumes from that value on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| load_n | input | 1 | Active-low, level-sensitive load of `din` |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | 0 = count up, 1 = count down |
| din | input | WIDTH | Value to load |
| count | output | WIDTH | Present count |
| term_cnt | output | 1 | Terminal count in the selected direction while enabled |
| ripple_n | output | 1 | Active-low pulse during the low clock phase at terminal count |

## Verification
A count step is due one rising edge after the inputs that request it. A load shows on `count` in the same cycle, and `term_cnt` follows combinationally from `count` and the present inputs. The bench therefore changes inputs three nanoseconds after a falling edge and reads results three nanoseconds after the next falling edge, which is one rising edge later and in the low clock phase where `ripple_n` can be low. Two effects are read before any edge: the immediate load and the asynchronous clear, each checked one nanosecond after the input changes. The high-phase value of `ripple_n` is read three nanoseconds after a rising edge.

// File: rtl/updn_pkg.sv
// Shared definitions for the up/down counter.
// Assumes: nothing; types only.
package updn_pkg;
    // Meaning of the direction input.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/updn_step.sv
// Next stored value for the counter: one step up or down from the
// presented value, or hold when counting is disabled.
// Assumes: cur is the value the block presents, so reload and load
// substitutions are already applied.
module updn_step
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             dir_down,
    input  logic             en_n,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Pick increment, decrement or hold; the natural wrap of WIDTH bits is intended.
    always_comb begin
        if (en_n) begin
            nxt = cur;
        end else if (dir_e'(dir_down) == DIR_DOWN) begin
            nxt = cur - ONE;
        end else begin
            nxt = cur + ONE;
        end
    end
endmodule

// File: rtl/updn_view.sv
// Presented count: the data bus while load is active, otherwise the
// stored value. In reload mode a stored zero is replaced by the preset.
// Assumes: PRESET fits in WIDTH bits.
module updn_view #(
    parameter int WIDTH     = 4,
    parameter bit RELOAD_EN = 1'b0,
    parameter int PRESET    = 6
) (
    input  logic [WIDTH-1:0] cnt_q,
    input  logic [WIDTH-1:0] din,
    input  logic             load_n,
    output logic [WIDTH-1:0] view
);
    localparam logic [WIDTH-1:0] PRESET_V = WIDTH'(PRESET);

    logic [WIDTH-1:0] stored_v;

    generate
        if (RELOAD_EN) begin : g_reload
            // Zero detector: a stored zero acts as a load of the preset.
            always_comb stored_v = (cnt_q == '0) ? PRESET_V : cnt_q;
        end else begin : g_plain
            // Plain counter: the stored value is shown as is.
            always_comb stored_v = cnt_q;
        end
    endgenerate

    // The data bus wins while load is held low.
    always_comb view = load_n ? stored_v : din;
endmodule

// File: rtl/updn_flags.sv
// Terminal-count flag and active-low ripple output.
// Assumes: clk is the counter clock; ripple_n is combinational in clk.
module updn_flags #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] view,
    input  logic             dir_down,
    input  logic             en_n,
    output logic             term_cnt,
    output logic             ripple_n
);
    localparam logic [WIDTH-1:0] TOP_V = '1;

    // Last value in the selected direction, gated by the enable.
    always_comb term_cnt = !en_n && (dir_down ? (view == '0) : (view == TOP_V));

    // Low only for the low clock phase at terminal count.
    always_comb ripple_n = !(term_cnt && !clk);
endmodule

// File: rtl/updn_counter.sv
// Presettable up/down counter, top level.
// Assumes: din is stable while load_n is low and across the clock edge
// that precedes the release of load_n, so the stored copy matches.
module updn_counter #(
    parameter int WIDTH     = 4,
    parameter bit RELOAD_EN = 1'b0,
    parameter int PRESET    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             dir_down,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             term_cnt,
    output logic             ripple_n
);
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] view;
    logic [WIDTH-1:0] nxt;

    updn_view #(
        .WIDTH    (WIDTH),
        .RELOAD_EN(RELOAD_EN),
        .PRESET   (PRESET)
    ) u_view (
        .cnt_q (cnt_q),
        .din   (din),
        .load_n(load_n),
        .view  (view)
    );

    updn_step #(
        .WIDTH(WIDTH)
    ) u_step (
        .cur     (view),
        .dir_down(dir_down),
        .en_n    (cnt_en_n),
        .nxt     (nxt)
    );

    updn_flags #(
        .WIDTH(WIDTH)
    ) u_flags (
        .clk     (clk),
        .view    (view),
        .dir_down(dir_down),
        .en_n    (cnt_en_n),
        .term_cnt(term_cnt),
        .ripple_n(ripple_n)
    );

    // Count store: async clear, async/level load of din, otherwise step on the rising edge.
    always_ff @(posedge clk or negedge rst_n or negedge load_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!load_n) begin
            cnt_q <= din;
        end else begin
            cnt_q <= nxt;
        end
    end

    // The presented value is the block's count.
    always_comb count = view;
endmodule

// File: rtl/updn_counter_chk.sv
// Property checker for updn_counter, attached with bind.
// Assumes: no load pulse begins and ends between two rising edges.
module updn_counter_chk #(
    parameter int WIDTH     = 4,
    parameter bit RELOAD_EN = 1'b0,
    parameter int PRESET    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             cnt_en_n,
    input logic             dir_down,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] count,
    input logic             term_cnt,
    input logic             ripple_n
);
    localparam logic [WIDTH-1:0] PRESET_V = WIDTH'(PRESET);
    localparam logic [WIDTH-1:0] TOP_V    = '1;

    // Value shown for a given stored value.
    function automatic logic [WIDTH-1:0] shown(input logic [WIDTH-1:0] v);
        return (RELOAD_EN && v == '0) ? PRESET_V : v;
    endfunction

    p_clear_r1: assert property (@(posedge clk) !rst_n |-> count == shown('0));

    p_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !dir_down) |=>
        (!load_n || count == shown(WIDTH'($past(count) + 1'b1))));

    p_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && dir_down) |=>
        (!load_n || count == shown(WIDTH'($past(count) - 1'b1))));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_n) |=> (!load_n || $stable(count)));

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (!load_n || count == shown($past(din))));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !dir_down && count == TOP_V) |=>
        (!load_n || count == shown('0)));

    p_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt |-> (!cnt_en_n && (dir_down ? count == '0 : count == TOP_V)));

    p_tcoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en_n |-> !term_cnt);

    // Sampled just before the rising edge, i.e. in the low phase.
    p_rc_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ripple_n == !term_cnt);

    // Sampled just before the falling edge, i.e. in the high phase.
    p_rc_high_r8: assert property (@(negedge clk) disable iff (!rst_n)
        ripple_n);
endmodule

bind updn_counter updn_counter_chk #(
    .WIDTH    (WIDTH),
    .RELOAD_EN(RELOAD_EN),
    .PRESET   (PRESET)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .cnt_en_n(cnt_en_n),
    .dir_down(dir_down),
    .din     (din),
    .count   (count),
    .term_cnt(term_cnt),
    .ripple_n(ripple_n)
);

// File: tb/updn_counter_tb_top.sv
// Self-checking bench for updn_counter: vector table, then directed tests.
module updn_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       load_n = 1'b1;
    logic       cnt_en_n = 1'b1;
    logic       dir_down = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] count;
    logic       term_cnt;
    logic       ripple_n;

    logic       rl_en_n = 1'b1;
    logic [3:0] count_rl;
    logic       term_cnt_rl;
    logic       ripple_rl_n;

    int n_cmp = 0;
    int n_bad = 0;
    logic [11:0] v;

    always #5 clk = ~clk;   // 100 MHz

    updn_counter #(.WIDTH(4), .RELOAD_EN(1'b0), .PRESET(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_n(cnt_en_n),
        .dir_down(dir_down), .din(din), .count(count),
        .term_cnt(term_cnt), .ripple_n(ripple_n)
    );

    updn_counter #(.WIDTH(4), .RELOAD_EN(1'b1), .PRESET(6)) dut_rl_i (
        .clk(clk), .rst_n(rst_n), .load_n(1'b1), .cnt_en_n(rl_en_n),
        .dir_down(1'b0), .din(4'd0), .count(count_rl),
        .term_cnt(term_cnt_rl), .ripple_n(ripple_rl_n)
    );

    // Vector: {load_n, cnt_en_n, dir_down, din[3:0], expected count[3:0], expected term_cnt}
    localparam logic [11:0] VEC [12] = '{
        12'b0_1_0_1101_1101_0,  // R5 load 13, enable off
        12'b1_0_0_0000_1110_0,  // R2 up to 14
        12'b1_0_0_0000_1111_1,  // R2/R7 up to 15, terminal
        12'b1_0_0_0000_0000_0,  // R6 wrap 15 -> 0
        12'b1_0_1_0000_1111_0,  // R6 wrap 0 -> 15 downward
        12'b1_0_1_0000_1110_0,  // R3 down to 14
        12'b1_1_1_0000_1110_0,  // R4 hold
        12'b0_0_1_0010_0010_0,  // R5 load wins over enabled count
        12'b1_0_1_0000_0001_0,  // R10/R3 resume from 2 -> 1
        12'b1_0_1_0000_0000_1,  // R3/R7 down to 0, terminal
        12'b1_1_1_0000_0000_0,  // R7 flag gated off by enable
        12'b1_0_0_0000_0001_0   // R2 up to 1
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic low_phase();
        @(negedge clk);
        #3;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, checked before any clock edge.
        #1 rst_n = 1'b0;
        #2;
        chk("R1 count in reset", int'(count), 0);
        chk("R7 term_cnt in reset", int'(term_cnt), 0);
        chk("R8 ripple_n in reset", int'(ripple_n), 1);
        chk("R9 reload count in reset", int'(count_rl), 6);
        low_phase();
        rst_n = 1'b1;

        // Table walk: apply in low phase, result due after the next rising edge.
        for (int i = 0; i < 12; i++) begin
            v = VEC[i];
            load_n   = v[11];
            cnt_en_n = v[10];
            dir_down = v[9];
            din      = v[8:5];
            low_phase();
            chk($sformatf("table step %0d count (R2/R3/R4/R5/R6/R10)", i), int'(count), int'(v[4:1]));
            chk($sformatf("table step %0d term_cnt (R7)", i), int'(term_cnt), int'(v[0]));
            chk($sformatf("table step %0d ripple_n low phase (R8)", i), int'(ripple_n), int'(!v[0]));
        end

        // R5: load takes effect with no clock edge.
        load_n = 1'b0; cnt_en_n = 1'b1; din = 4'd9;
        #1;
        chk("R5 immediate load", int'(count), 9);
        low_phase();
        // R10: release keeps the loaded value, then counting resumes.
        load_n = 1'b1; cnt_en_n = 1'b0; dir_down = 1'b0;
        #1;
        chk("R10 value kept after release", int'(count), 9);
        low_phase();
        chk("R10 count resumes from loaded value", int'(count), 10);

        // R8: ripple output in the high and low phases at terminal count.
        @(posedge clk);
        #2;
        load_n = 1'b0; din = 4'd15;
        #1;
        chk("R7 terminal at 15 up", int'(term_cnt), 1);
        chk("R8 ripple_n high in high phase", int'(ripple_n), 1);
        low_phase();
        chk("R8 ripple_n low in low phase", int'(ripple_n), 0);

        // R1: asynchronous clear in mid-cycle.
        load_n = 1'b1; cnt_en_n = 1'b1;
        #1;
        chk("R4 hold at 15 before clear", int'(count), 15);
        rst_n = 1'b0;
        #1;
        chk("R1 async clear", int'(count), 0);
        low_phase();
        rst_n = 1'b1;

        // R9: reload sequence 6..15 then 6 again.
        rl_en_n = 1'b0;
        for (int i = 1; i <= 11; i++) begin
            low_phase();
            chk($sformatf("R9 reload step %0d", i), int'(count_rl), (6 + i > 15) ? (6 + i - 10) : (6 + i));
            if (i == 9) chk("R9 reload terminal at 15", int'(term_cnt_rl), 1);
        end
        rl_en_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule